// File: doc/BRIEF.md
# Event-Driven Spiking Crossbar Core

This block is one neural core of a spiking processor. It joins a set of input axons to a set of neurons through a crossbar of one-bit synapses. Spike events arrive as packets that carry a target axon and a delay. A ring of time slots holds each spike until the step in which it is due. Each step starts with a slow tick. On a tick the controller takes the axons that are due and visits only those. For each such axon it walks every neuron and adds a weight to the potential of each neuron that the axon's synapse connects. After that it leaks each neuron, compares each neuron with its threshold and sends out spike packets.

One arithmetic datapath is shared in time by every neuron. Potentials sit in an on-core array that is read and written one neuron per cycle. A single 16-bit pseudo-random generator adds programmable noise to the thresholds. Synapses, axon types, neuron parameters and the generator seed are written through simple write strobes while the core is idle.

Top module: `nsc_core`

## Requirements
- R1: On an accepted tick, each due axon is processed in ascending axon order, and for each one the neurons are processed in ascending order. Every neuron whose crossbar bit for that axon is 1 adds the weight chosen by the axon's 2-bit type. The weight for type k is bits [9k+8:9k] of the neuron's weight word, read as a signed value.
- R2: A spike with delay d (1 to 15) is integrated at the d-th accepted tick after the cycle in which it arrives; a tick in that same cycle does not count. Several spikes to one axon that fall due on the same tick count as one activation.
- R3: A spike packet with delay 0 is discarded and has no effect on any later step.
- R4: After integration, each neuron in ascending order has its signed leak added. It fires when its potential is at least its signed threshold plus (random value AND mask), compared without overflow. A neuron that fires loads its programmed reset potential.
- R5: Every addition to a potential saturates at the signed range of POT_W bits.
- R6: The random source is a 16-bit LFSR with next value {r[14:0], r[15]^r[13]^r[12]^r[10]}. It resets to 1, and a seed write loads the seed, with a seed of 0 loaded as 1. Each neuron evaluation in the leak phase draws the current value and then advances the register once.
- R7: A tick sampled while idle starts a step. busy then stays high for exactly A*N_NEURON + N_NEURON + 1 cycles, where A is the number of distinct axons due.
- R8: A tick that arrives while busy is ignored: no step starts and the scheduler does not advance.
- R9: Each firing neuron produces a one-cycle out_valid pulse carrying that neuron's programmed target axon and delay. Pulses come in ascending neuron order and only during or at the end of a step.
- R10: After reset, busy and out_valid are 0 and every potential is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-step strobe |
| in_valid | input | 1 | Incoming spike packet strobe |
| in_axon | input | log2(N_AXON) | Target axon of the incoming spike |
| in_delay | input | log2(SLOTS) | Delivery delay in steps |
| syn_we | input | 1 | Crossbar bit write strobe |
| syn_axon | input | log2(N_AXON) | Crossbar row to write |
| syn_neuron | input | log2(N_NEURON) | Crossbar column to write |
| syn_val | input | 1 | Synapse connected (1) or open (0) |
| type_we | input | 1 | Axon type write strobe |
| type_axon | input | log2(N_AXON) | Axon whose type is written |
| type_val | input | 2 | Axon type |
| nrn_we | input | 1 | Neuron parameter write strobe |
| nrn_idx | input | log2(N_NEURON) | Neuron to configure |
| nrn_weights | input | 4*W_W | Four signed weights, one per axon type |
| nrn_leak | input | W_W | Signed leak |
| nrn_thresh | input | POT_W | Signed threshold |
| nrn_reset | input | POT_W | Signed potential after firing |
| nrn_mask | input | 16 | Mask applied to the random value |
| nrn_tgt_axon | input | log2(N_AXON) | Axon named in this neuron's output spikes |
| nrn_tgt_delay | input | log2(SLOTS) | Delay named in this neuron's output spikes |
| seed_we | input | 1 | Random seed write strobe |
| seed | input | 16 | Seed value |
| busy | output | 1 | A time step is in progress |
| out_valid | output | 1 | Output spike packet strobe |
| out_axon | output | log2(N_AXON) | Target axon of the output spike |
| out_delay | output | log2(SLOTS) | Delay of the output spike |

## Verification
The bench builds the core with 8 axons, 8 neurons and a 12-bit potential, and it keeps the 16-slot delay ring. With 8 by 8, a reference model can follow every crosspoint, and every step lasts well under a hundred cycles, so dozens of steps fit in the run and the slot pointer wraps several times. The narrow potential means positive and negative saturation are reached after about nine spikes of large weight. Wrapping arithmetic would then produce a visibly different firing pattern.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    localparam int TYPE_W = 2;
    localparam int TYPE_N = 1 << TYPE_W;
    localparam int RND_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_LEAK  = 2'd2
    } step_e;

endpackage

// File: rtl/nsc_sched.sv
module nsc_sched #(
    parameter int N_AXON = 256,
    parameter int SLOTS  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      take,
    input  logic                      in_valid,
    input  logic [$clog2(N_AXON)-1:0] in_axon,
    input  logic [$clog2(SLOTS)-1:0]  in_delay,
    output logic [N_AXON-1:0]         due
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] ONE_S = SLOT_W'(1);

    typedef struct packed {
        logic [SLOTS-1:0][N_AXON-1:0] ring;
        logic [SLOT_W-1:0]            ptr;
    } sched_t;

    sched_t st_d, st_q;
    logic [SLOT_W-1:0] base;

    // the slot read on a tick is the one after the pointer
    assign due = st_q.ring[st_q.ptr + ONE_S];

    always_comb begin
        st_d = st_q;
        base = st_q.ptr;
        if (take) begin
            base = st_q.ptr + ONE_S;
            st_d.ptr = base;
            st_d.ring[base] = '0;
        end
        // spikes arriving with a tick count from the new pointer
        if (in_valid && (in_delay != '0)) begin
            st_d.ring[base + in_delay][in_axon] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nsc_lfsr.sv
module nsc_lfsr
    import nsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RND_W-1:0] seed,
    input  logic             adv,
    output logic [RND_W-1:0] rnd
);

    typedef struct packed {
        logic [RND_W-1:0] sr;
    } lfsr_t;

    lfsr_t st_d, st_q;
    logic  fb;

    assign fb  = st_q.sr[15] ^ st_q.sr[13] ^ st_q.sr[12] ^ st_q.sr[10];
    assign rnd = st_q.sr;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sr = (seed == '0) ? RND_W'(1) : seed;
        end else if (adv) begin
            st_d.sr = {st_q.sr[14:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sr <= RND_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nsc_alu.sv
module nsc_alu
    import nsc_pkg::*;
#(
    parameter int POT_W = 20,
    parameter int W_W   = 9
) (
    input  logic [POT_W-1:0] pot,
    input  logic [W_W-1:0]   addend,
    input  logic [POT_W-1:0] thr,
    input  logic [POT_W-1:0] rst_val,
    input  logic [RND_W-1:0] rnd,
    input  logic [RND_W-1:0] mask,
    output logic [POT_W-1:0] sum,
    output logic             fire,
    output logic [POT_W-1:0] result
);

    localparam int EXT_W = POT_W + 1;
    localparam int CMP_W = ((POT_W > RND_W) ? POT_W : RND_W) + 2;
    localparam logic signed [EXT_W-1:0] PMAX = {2'b00, {(POT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] PMIN = {2'b11, {(POT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] wide;
    logic signed [CMP_W-1:0] sum_x, thr_x, rnd_x;

    always_comb begin
        wide = $signed({pot[POT_W-1], pot})
             + $signed({{(EXT_W-W_W){addend[W_W-1]}}, addend});
        if (wide > PMAX) begin
            sum = PMAX[POT_W-1:0];
        end else if (wide < PMIN) begin
            sum = PMIN[POT_W-1:0];
        end else begin
            sum = wide[POT_W-1:0];
        end
        sum_x  = {{(CMP_W-POT_W){sum[POT_W-1]}}, sum};
        thr_x  = {{(CMP_W-POT_W){thr[POT_W-1]}}, thr};
        rnd_x  = {{(CMP_W-RND_W){1'b0}}, rnd & mask};
        fire   = (sum_x >= (thr_x + rnd_x));
        result = fire ? rst_val : sum;
    end

endmodule

// File: rtl/nsc_core.sv
module nsc_core
    import nsc_pkg::*;
#(
    parameter int N_AXON   = 256,
    parameter int N_NEURON = 256,
    parameter int SLOTS    = 16,
    parameter int POT_W    = 20,
    parameter int W_W      = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        in_valid,
    input  logic [$clog2(N_AXON)-1:0]   in_axon,
    input  logic [$clog2(SLOTS)-1:0]    in_delay,
    input  logic                        syn_we,
    input  logic [$clog2(N_AXON)-1:0]   syn_axon,
    input  logic [$clog2(N_NEURON)-1:0] syn_neuron,
    input  logic                        syn_val,
    input  logic                        type_we,
    input  logic [$clog2(N_AXON)-1:0]   type_axon,
    input  logic [1:0]                  type_val,
    input  logic                        nrn_we,
    input  logic [$clog2(N_NEURON)-1:0] nrn_idx,
    input  logic [4*W_W-1:0]            nrn_weights,
    input  logic [W_W-1:0]              nrn_leak,
    input  logic [POT_W-1:0]            nrn_thresh,
    input  logic [POT_W-1:0]            nrn_reset,
    input  logic [15:0]                 nrn_mask,
    input  logic [$clog2(N_AXON)-1:0]   nrn_tgt_axon,
    input  logic [$clog2(SLOTS)-1:0]    nrn_tgt_delay,
    input  logic                        seed_we,
    input  logic [15:0]                 seed,
    output logic                        busy,
    output logic                        out_valid,
    output logic [$clog2(N_AXON)-1:0]   out_axon,
    output logic [$clog2(SLOTS)-1:0]    out_delay
);

    localparam int AX_W   = $clog2(N_AXON);
    localparam int NR_W   = $clog2(N_NEURON);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int WTS_W  = TYPE_N * W_W;
    localparam logic [NR_W-1:0] LAST_N = NR_W'(N_NEURON - 1);
    localparam logic [NR_W-1:0] ONE_N  = NR_W'(1);

    typedef struct packed {
        logic [WTS_W-1:0]  wts;
        logic [W_W-1:0]    leak;
        logic [POT_W-1:0]  thr;
        logic [POT_W-1:0]  rst;
        logic [RND_W-1:0]  mask;
        logic [AX_W-1:0]   ta;
        logic [SLOT_W-1:0] td;
    } nrn_cfg_t;

    typedef struct packed {
        step_e             state;
        logic [N_AXON-1:0] active;
        logic [NR_W-1:0]   nidx;
        logic              out_valid;
        logic [AX_W-1:0]   out_axon;
        logic [SLOT_W-1:0] out_delay;
    } ctl_t;

    // programmable storage
    logic [N_NEURON-1:0] xbar_q [N_AXON];
    logic [TYPE_W-1:0]   type_q [N_AXON];
    nrn_cfg_t            cfg_q  [N_NEURON];
    logic [POT_W-1:0]    pot_q  [N_NEURON];

    ctl_t ctl_d, ctl_q;

    logic              take;
    logic [N_AXON-1:0] due_vec;
    logic [AX_W-1:0]   sel;
    logic              any_act;
    nrn_cfg_t          cur_cfg;
    logic [TYPE_W-1:0] cur_type;
    logic [W_W-1:0]    weight;
    logic              syn_hit;
    logic              in_leak;
    logic [W_W-1:0]    addend;
    logic [RND_W-1:0]  rnd_val;
    logic [POT_W-1:0]  alu_sum;
    logic [POT_W-1:0]  alu_res;
    logic              alu_fire;
    logic              pot_we;
    logic [POT_W-1:0]  pot_wd;

    assign take = tick && (ctl_q.state == ST_IDLE);

    nsc_sched #(
        .N_AXON (N_AXON),
        .SLOTS  (SLOTS)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .in_valid (in_valid),
        .in_axon  (in_axon),
        .in_delay (in_delay),
        .due      (due_vec)
    );

    nsc_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_we),
        .seed  (seed),
        .adv   (in_leak),
        .rnd   (rnd_val)
    );

    // lowest pending axon
    always_comb begin
        sel = '0;
        for (int i = N_AXON - 1; i >= 0; i--) begin
            if (ctl_q.active[i]) begin
                sel = AX_W'(i);
            end
        end
    end

    assign any_act  = |ctl_q.active;
    assign cur_cfg  = cfg_q[ctl_q.nidx];
    assign cur_type = type_q[sel];
    assign weight   = cur_cfg.wts[int'(cur_type) * W_W +: W_W];
    assign syn_hit  = xbar_q[sel][ctl_q.nidx];
    assign in_leak  = (ctl_q.state == ST_LEAK);
    assign addend   = in_leak ? cur_cfg.leak : weight;

    nsc_alu #(
        .POT_W (POT_W),
        .W_W   (W_W)
    ) u_alu (
        .pot     (pot_q[ctl_q.nidx]),
        .addend  (addend),
        .thr     (cur_cfg.thr),
        .rst_val (cur_cfg.rst),
        .rnd     (rnd_val),
        .mask    (cur_cfg.mask),
        .sum     (alu_sum),
        .fire    (alu_fire),
        .result  (alu_res)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.out_valid = 1'b0;
        pot_we          = 1'b0;
        pot_wd          = alu_sum;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (take) begin
                    ctl_d.state  = ST_INTEG;
                    ctl_d.active = due_vec;
                    ctl_d.nidx   = '0;
                end
            end
            ST_INTEG: begin
                if (!any_act) begin
                    ctl_d.state = ST_LEAK;
                    ctl_d.nidx  = '0;
                end else begin
                    pot_we = syn_hit;
                    if (ctl_q.nidx == LAST_N) begin
                        ctl_d.nidx        = '0;
                        ctl_d.active[sel] = 1'b0;
                    end else begin
                        ctl_d.nidx = ctl_q.nidx + ONE_N;
                    end
                end
            end
            ST_LEAK: begin
                pot_we = 1'b1;
                pot_wd = alu_res;
                if (alu_fire) begin
                    ctl_d.out_valid = 1'b1;
                    ctl_d.out_axon  = cur_cfg.ta;
                    ctl_d.out_delay = cur_cfg.td;
                end
                if (ctl_q.nidx == LAST_N) begin
                    ctl_d.state = ST_IDLE;
                end else begin
                    ctl_d.nidx = ctl_q.nidx + ONE_N;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_NEURON; i++) begin
                pot_q[i] <= '0;
            end
        end else if (pot_we) begin
            pot_q[ctl_q.nidx] <= pot_wd;
        end
    end

    always_ff @(posedge clk) begin
        if (syn_we) begin
            xbar_q[syn_axon][syn_neuron] <= syn_val;
        end
        if (type_we) begin
            type_q[type_axon] <= type_val;
        end
        if (nrn_we) begin
            cfg_q[nrn_idx] <= '{wts:  nrn_weights,
                                leak: nrn_leak,
                                thr:  nrn_thresh,
                                rst:  nrn_reset,
                                mask: nrn_mask,
                                ta:   nrn_tgt_axon,
                                td:   nrn_tgt_delay};
        end
    end

    assign busy      = (ctl_q.state != ST_IDLE);
    assign out_valid = ctl_q.out_valid;
    assign out_axon  = ctl_q.out_axon;
    assign out_delay = ctl_q.out_delay;

endmodule

// File: rtl/nsc_core_chk.sv
module nsc_core_chk #(
    parameter int SLOTS = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     tick,
    input logic                     busy,
    input logic                     out_valid,
    input logic [$clog2(SLOTS)-1:0] ptr,
    input logic [15:0]              rnd
);

    localparam int SLOT_W = $clog2(SLOTS);

    // R7: an idle tick always opens a step
    assert_tick_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy) |=> busy);

    // R2: an accepted tick moves the slot pointer by exactly one
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !busy) |=> (ptr == SLOT_W'($past(ptr) + 1)));

    // R8: no slot advance while a step runs
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));

    // R9: output pulses only come out of a running step
    assert_out_in_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(busy));

    // R6: the random register never locks up at zero
    assert_rnd_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rnd != 16'h0000);

endmodule

bind nsc_core nsc_core_chk #(.SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .busy      (busy),
    .out_valid (out_valid),
    .ptr       (u_sched.st_q.ptr),
    .rnd       (rnd_val)
);

// File: tb/sim_nsc_core.sv
module sim_nsc_core;

    localparam int NA   = 8;
    localparam int NN   = 8;
    localparam int PW   = 12;
    localparam int WW   = 9;
    localparam int PMAX = 2047;
    localparam int PMIN = -2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_axon = '0;
    logic [3:0]  in_delay = '0;
    logic        syn_we = 1'b0;
    logic [2:0]  syn_axon = '0;
    logic [2:0]  syn_neuron = '0;
    logic        syn_val = 1'b0;
    logic        type_we = 1'b0;
    logic [2:0]  type_axon = '0;
    logic [1:0]  type_val = '0;
    logic        nrn_we = 1'b0;
    logic [2:0]  nrn_idx = '0;
    logic [35:0] nrn_weights = '0;
    logic [8:0]  nrn_leak = '0;
    logic [11:0] nrn_thresh = '0;
    logic [11:0] nrn_reset = '0;
    logic [15:0] nrn_mask = '0;
    logic [2:0]  nrn_tgt_axon = '0;
    logic [3:0]  nrn_tgt_delay = '0;
    logic        seed_we = 1'b0;
    logic [15:0] seed = '0;
    logic        busy;
    logic        out_valid;
    logic [2:0]  out_axon;
    logic [3:0]  out_delay;

    always #10 clk = ~clk;

    nsc_core #(
        .N_AXON   (NA),
        .N_NEURON (NN),
        .SLOTS    (16),
        .POT_W    (PW),
        .W_W      (WW)
    ) u0 (.*);

    int n_total = 0;
    int n_fail  = 0;

    // reference state
    bit   xbar_m [NA][NN];
    int   type_m [NA];
    int   w_m    [NN][4];
    int   leak_m [NN];
    int   thr_m  [NN];
    int   rst_m  [NN];
    int   mask_m [NN];
    int   ta_m   [NN];
    int   td_m   [NN];
    int   pot_m  [NN];
    logic [15:0] lfsr_m = 16'h0001;
    logic [NA-1:0] due_m [1024];
    int   tick_count = 0;
    int   exp_ax [NN];
    int   exp_dl [NN];
    int   exp_n;

    // output monitor
    int mon_n = 0;
    int got_ax [1024];
    int got_dl [1024];
    always @(negedge clk) begin
        if (out_valid) begin
            got_ax[mon_n % 1024] = int'(out_axon);
            got_dl[mon_n % 1024] = int'(out_delay);
            mon_n++;
        end
    end

    task automatic chk(input bit ok, input string what, input int got, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    function automatic int sat(input int v);
        if (v > PMAX) return PMAX;
        if (v < PMIN) return PMIN;
        return v;
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] r);
        return {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
    endfunction

    task automatic set_syn(input int a, input int n, input bit v);
        @(negedge clk);
        syn_we = 1'b1; syn_axon = 3'(a); syn_neuron = 3'(n); syn_val = v;
        @(negedge clk);
        syn_we = 1'b0;
        xbar_m[a][n] = v;
    endtask

    task automatic set_type(input int a, input int t);
        @(negedge clk);
        type_we = 1'b1; type_axon = 3'(a); type_val = 2'(t);
        @(negedge clk);
        type_we = 1'b0;
        type_m[a] = t;
    endtask

    task automatic set_nrn(input int n, input int w0, input int w1, input int w2,
                           input int w3, input int lk, input int th, input int rs,
                           input int mk, input int ta, input int td);
        @(negedge clk);
        nrn_we = 1'b1; nrn_idx = 3'(n);
        nrn_weights = {9'(w3), 9'(w2), 9'(w1), 9'(w0)};
        nrn_leak = 9'(lk); nrn_thresh = 12'(th); nrn_reset = 12'(rs);
        nrn_mask = 16'(mk); nrn_tgt_axon = 3'(ta); nrn_tgt_delay = 4'(td);
        @(negedge clk);
        nrn_we = 1'b0;
        w_m[n][0] = w0; w_m[n][1] = w1; w_m[n][2] = w2; w_m[n][3] = w3;
        leak_m[n] = lk; thr_m[n] = th; rst_m[n] = rs; mask_m[n] = mk;
        ta_m[n] = ta; td_m[n] = td;
    endtask

    task automatic set_seed(input logic [15:0] s);
        @(negedge clk);
        seed_we = 1'b1; seed = s;
        @(negedge clk);
        seed_we = 1'b0;
        lfsr_m = (s == 16'h0000) ? 16'h0001 : s;
    endtask

    task automatic spike(input int a, input int d);
        @(negedge clk);
        in_valid = 1'b1; in_axon = 3'(a); in_delay = 4'(d);
        @(negedge clk);
        in_valid = 1'b0;
        if (d != 0) due_m[tick_count + d][a] = 1'b1;
    endtask

    // one time step: model prediction, then compare at the ports
    task automatic do_step(input string tag, input bit extra);
        int a_cnt = 0;
        int bc = 0;
        int base;
        int exp_bc;
        logic [NA-1:0] act;
        logic [15:0] r;
        tick_count++;
        act = due_m[tick_count];
        exp_n = 0;
        for (int a = 0; a < NA; a++) begin
            if (act[a]) begin
                a_cnt++;
                for (int n = 0; n < NN; n++)
                    if (xbar_m[a][n]) pot_m[n] = sat(pot_m[n] + w_m[n][type_m[a]]);
            end
        end
        for (int n = 0; n < NN; n++) begin
            pot_m[n] = sat(pot_m[n] + leak_m[n]);
            r = lfsr_m;
            lfsr_m = lfsr_next(lfsr_m);
            if (pot_m[n] >= thr_m[n] + int'(r & 16'(mask_m[n]))) begin
                exp_ax[exp_n] = ta_m[n];
                exp_dl[exp_n] = td_m[n];
                exp_n++;
                pot_m[n] = rst_m[n];
            end
        end
        exp_bc = a_cnt * NN + NN + 1;
        base = mon_n;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        while (busy) begin
            bc++;
            tick = (extra && bc == 2);
            @(negedge clk);
        end
        tick = 1'b0;
        @(negedge clk);
        chk(bc == exp_bc, {tag, " R7 busy length"}, bc, exp_bc);
        chk((mon_n - base) == exp_n, {tag, " R4 R9 spike count"}, mon_n - base, exp_n);
        for (int i = 0; i < exp_n && i < mon_n - base; i++) begin
            chk(got_ax[(base + i) % 1024] == exp_ax[i], {tag, " R1 R9 spike axon"},
                got_ax[(base + i) % 1024], exp_ax[i]);
            chk(got_dl[(base + i) % 1024] == exp_dl[i], {tag, " R9 spike delay"},
                got_dl[(base + i) % 1024], exp_dl[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int junk;
        junk = $urandom(20240611);
        for (int i = 0; i < 1024; i++) due_m[i] = '0;
        for (int n = 0; n < NN; n++) pot_m[n] = 0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
        chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;

        // R10: potentials start at zero, so threshold 0 fires everyone once
        for (int a = 0; a < NA; a++) begin
            set_type(a, 0);
            for (int n = 0; n < NN; n++) set_syn(a, n, 1'b0);
        end
        for (int n = 0; n < NN; n++) set_nrn(n, 0, 0, 0, 0, 0, 0, 0, 0, n, 1);
        set_seed(16'hACE1);
        do_step("R10", 1'b0);
        for (int n = 0; n < NN; n++) set_nrn(n, 0, 0, 0, 0, 0, 1, 0, 0, NN - 1 - n, 2);
        do_step("R10 quiet", 1'b0);

        // R5: positive and negative saturation
        set_type(1, 1);
        set_type(2, 2);
        set_syn(0, 0, 1'b1);
        set_syn(1, 1, 1'b1);
        set_syn(2, 1, 1'b1);
        set_nrn(0, 255, 0, 0, 0, 0, 2047, 0, 0, 5, 3);
        set_nrn(1, 0, -256, 255, 0, 0, 1000, 0, 0, 6, 4);
        for (int k = 0; k < 11; k++) begin
            spike(0, 1);
            spike(1, 1);
            do_step("R5 sat", 1'b0);
        end
        for (int k = 0; k < 6; k++) begin
            spike(2, 1);
            do_step("R5 recover", 1'b0);
        end

        // R3 and R2: zero delay dropped, long delay, duplicates merged
        set_type(3, 3);
        set_syn(3, 2, 1'b1);
        set_nrn(2, 0, 0, 0, 100, 0, 150, 0, 0, 7, 15);
        spike(3, 0);
        spike(3, 15);
        spike(3, 15);
        spike(0, 0);
        for (int k = 0; k < 16; k++) do_step("R2 R3 delay", 1'b0);

        // R8: a tick during a step is ignored
        spike(3, 2);
        spike(0, 1);
        do_step("R8 extra tick", 1'b1);
        do_step("R8 follow", 1'b0);
        do_step("R8 settle", 1'b0);

        // R6: stochastic thresholds, seed 0 loads as 1
        set_seed(16'h0000);
        for (int n = 0; n < NN; n++)
            set_nrn(n, 40, 60, -30, 90, -3, 50, -10, 16'h00FF, n, n + 1);
        for (int a = 0; a < NA; a++)
            for (int n = 0; n < NN; n++) set_syn(a, n, (a + n) % 3 == 0);
        for (int k = 0; k < 8; k++) begin
            spike(k % NA, 1 + k % 4);
            spike((k * 3) % NA, 2);
            do_step("R6 noise", 1'b0);
        end

        // R1: constrained random configuration and traffic
        set_seed(16'h1D2B);
        for (int a = 0; a < NA; a++) begin
            set_type(a, int'($urandom_range(3)));
            for (int n = 0; n < NN; n++) set_syn(a, n, 1'($urandom_range(1)));
        end
        for (int n = 0; n < NN; n++)
            set_nrn(n, int'($urandom_range(511)) - 256, int'($urandom_range(511)) - 256,
                    int'($urandom_range(511)) - 256, int'($urandom_range(511)) - 256,
                    int'($urandom_range(25)) - 20, int'($urandom_range(600)) - 100,
                    -int'($urandom_range(50)), int'($urandom_range(255)),
                    int'($urandom_range(7)), int'($urandom_range(15)));
        for (int k = 0; k < 40; k++) begin
            for (int s = 0; s < int'($urandom_range(4)); s++)
                spike(int'($urandom_range(NA - 1)), int'($urandom_range(15)));
            do_step("R1 random", 1'b0);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule